// File: doc/BRIEF.md
# TTL Input Edge Timestamper

This block watches a single TTL line that arrives as a parallel word of `SAMPLES` sub-cycle samples per clock. Bit 0 of the word is the earliest sample and the highest bit is the latest. The block finds level changes inside each word and also on the seam between one word and the next. When it finds a change of a kind that software has enabled, it raises a one-cycle strobe and reports a fine timestamp. The timestamp is the bit index at which the new level first appears. A coarse timestamp taken from the strobe cycle and this fine index together place the edge with sub-cycle resolution.

The kinds of edge that are reported are held in a sensitivity state machine. The state is loaded by a strobed address/data command. It has four named states: `SENS_OFF` reports nothing, `SENS_RISE` reports low-to-high changes only, `SENS_FALL` reports high-to-low changes only, and `SENS_BOTH` reports either kind. There is one transition per state, taken on a command write that hits the sensitivity address. Data value 0 goes to `SENS_OFF`, 1 to `SENS_RISE`, 2 to `SENS_FALL` and 3 to `SENS_BOTH`. Any other command leaves the state where it is. Reset forces `SENS_OFF`.

The sample path has two register stages. The first stage captures the incoming word together with the last bit of the word before it. The second stage holds the strobe and the fine index of the earliest enabled edge.

Top module: `ttl_edge_stamper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `evt_stb_o` is 0 and `evt_fine_o` is 0. Reset returns the sensitivity to `SENS_OFF`, so a word that holds an edge and is presented right after reset produces no strobe.
- R2: A write is a cycle with `cmd_stb_i`=1 and `cmd_addr_i`=2. Such a write loads the sensitivity: `cmd_data_i` bit 0 enables rising edges and bit 1 enables falling edges. Words registered after the write edge are judged with the new setting.
- R3: A command to any other address, or a cycle with `cmd_stb_i`=0, leaves the sensitivity unchanged.
- R4: The fine timestamp is the index of the first bit that shows the new level, with bit 0 the earliest. After a low word, 8'hFE reports a rise at 1, 8'hC0 reports a rise at 6, and 8'h80 reports a rise at 7.
- R5: After an all-ones word, 8'h7F reports a fall at 7.
- R6: Bit 0 of each word is compared with the last bit of the previous word. 8'h00 after 8'h80 reports a fall at 0, and 8'h01 after 8'h7F reports a rise at 0.
- R7: Edges of a disabled kind produce no strobe. With rising only enabled, 8'h0F after 8'hFF is silent and 8'hF0 after 8'h00 reports 4.
- R8: When a word holds several enabled edges, only the earliest is reported. With both kinds enabled, 8'hAA after 8'h00 reports 1. With falling only enabled, 8'h55 after 8'h01 reports 1.
- R9: No strobe is produced while the sensitivity is `SENS_OFF` or while the line is steady. `evt_fine_o` reads 0 whenever `evt_stb_o` is 0.
- R10: The strobe is a one-cycle pulse. A word presented before clock edge k is registered at edge k, and its result appears after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_stb_i | input | 1 | Command strobe |
| cmd_addr_i | input | ADDR_W | Command address; 2 selects the sensitivity |
| cmd_data_i | input | DATA_W | Command data; bit 0 enables rising edges, bit 1 enables falling edges |
| sample_i | input | SAMPLES | Parallel sample word, bit 0 earliest |
| evt_stb_o | output | 1 | One-cycle pulse for an enabled edge |
| evt_fine_o | output | FINE_W | Bit index of the earliest enabled edge |

## Verification
The hardest case to reach from the ports is an edge on the seam between two words. It exists only if the previous word ended at the other level, and every sensitivity write also holds the sample input still for extra cycles. The bench therefore holds every word for two clocks, so each word is followed by a copy of itself. It orders the vector table so that the last bit of one row sets up the bit-0 comparison of the next. Rows that carry several edges are run under different sensitivity states, so that the earliest-enabled rule and the ignored kinds are each seen on their own.

// File: rtl/ttl_stamp_pkg.sv
package ttl_stamp_pkg;

    // Sensitivity states; the encoding matches command data bits {fall, rise}
    typedef enum logic [1:0] {
        SENS_OFF  = 2'b00,
        SENS_RISE = 2'b01,
        SENS_FALL = 2'b10,
        SENS_BOTH = 2'b11
    } sens_state_t;

endpackage

// File: rtl/ttl_stamp_sens.sv
module ttl_stamp_sens
    import ttl_stamp_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 2,
    parameter int SENS_ADDR = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_data_i,
    output logic              en_rise_o,
    output logic              en_fall_o
);

    sens_state_t state_q, state_d;
    logic        wr_hit;

    assign wr_hit = cmd_stb_i && (cmd_addr_i == ADDR_W'(SENS_ADDR));

    // Next state: only a write to the sensitivity address moves the machine
    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            unique case (cmd_data_i[1:0])
                2'b00:   state_d = SENS_OFF;
                2'b01:   state_d = SENS_RISE;
                2'b10:   state_d = SENS_FALL;
                default: state_d = SENS_BOTH;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SENS_OFF;
        else        state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            SENS_OFF:  begin en_rise_o = 1'b0; en_fall_o = 1'b0; end
            SENS_RISE: begin en_rise_o = 1'b1; en_fall_o = 1'b0; end
            SENS_FALL: begin en_rise_o = 1'b0; en_fall_o = 1'b1; end
            default:   begin en_rise_o = 1'b1; en_fall_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/ttl_stamp_edges.sv
module ttl_stamp_edges #(
    parameter int SAMPLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SAMPLES-1:0] sample_i,
    input  logic               en_rise_i,
    input  logic               en_fall_i,
    output logic [SAMPLES-1:0] hit_o
);

    logic [SAMPLES-1:0] word_q;
    logic               seam_q;   // last sample of the word before word_q

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            seam_q <= 1'b0;
        end else begin
            seam_q <= word_q[SAMPLES-1];
            word_q <= sample_i;
        end
    end

    // Each sample is compared with the one just before it in time
    genvar g;
    for (g = 0; g < SAMPLES; g++) begin : g_bit
        logic prior;
        if (g == 0) begin : g_seam
            assign prior = seam_q;
        end else begin : g_inner
            assign prior = word_q[g-1];
        end
        assign hit_o[g] = (en_rise_i &  word_q[g] & ~prior)
                        | (en_fall_i & ~word_q[g] &  prior);
    end

endmodule

// File: rtl/ttl_stamp_first.sv
module ttl_stamp_first #(
    parameter int SAMPLES = 8,
    parameter int FINE_W  = $clog2(SAMPLES)
) (
    input  logic [SAMPLES-1:0] req_i,
    output logic               found_o,
    output logic [FINE_W-1:0]  idx_o
);

    // Lowest set index wins: scan from the top so the earliest overwrites
    always_comb begin
        found_o = |req_i;
        idx_o   = '0;
        for (int i = SAMPLES - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = FINE_W'(i);
        end
    end

endmodule

// File: rtl/ttl_edge_stamper.sv
module ttl_edge_stamper #(
    parameter int SAMPLES   = 8,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 2,
    parameter int SENS_ADDR = 2,
    localparam int FINE_W   = $clog2(SAMPLES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_stb_i,
    input  logic [ADDR_W-1:0]  cmd_addr_i,
    input  logic [DATA_W-1:0]  cmd_data_i,
    input  logic [SAMPLES-1:0] sample_i,
    output logic               evt_stb_o,
    output logic [FINE_W-1:0]  evt_fine_o
);

    logic               en_rise, en_fall;
    logic [SAMPLES-1:0] hit_vec;
    logic               hit_any;
    logic [FINE_W-1:0]  hit_idx;

    ttl_stamp_sens #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SENS_ADDR (SENS_ADDR)
    ) u_sens (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb_i  (cmd_stb_i),
        .cmd_addr_i (cmd_addr_i),
        .cmd_data_i (cmd_data_i),
        .en_rise_o  (en_rise),
        .en_fall_o  (en_fall)
    );

    ttl_stamp_edges #(
        .SAMPLES (SAMPLES)
    ) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample_i),
        .en_rise_i (en_rise),
        .en_fall_i (en_fall),
        .hit_o     (hit_vec)
    );

    ttl_stamp_first #(
        .SAMPLES (SAMPLES),
        .FINE_W  (FINE_W)
    ) u_first (
        .req_i   (hit_vec),
        .found_o (hit_any),
        .idx_o   (hit_idx)
    );

    // Result stage: one-cycle pulse, index forced to zero when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_stb_o  <= 1'b0;
            evt_fine_o <= '0;
        end else begin
            evt_stb_o  <= hit_any;
            evt_fine_o <= hit_any ? hit_idx : '0;
        end
    end

endmodule

// File: rtl/ttl_edge_stamper_chk.sv
module ttl_edge_stamper_chk #(
    parameter int SAMPLES   = 8,
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 2,
    parameter int SENS_ADDR = 2,
    parameter int FINE_W    = $clog2(SAMPLES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_stb_i,
    input logic [ADDR_W-1:0]  cmd_addr_i,
    input logic [DATA_W-1:0]  cmd_data_i,
    input logic [SAMPLES-1:0] sample_i,
    input logic               evt_stb_o,
    input logic [FINE_W-1:0]  evt_fine_o
);

    // Port-side model: capture stage, then a one-cycle delayed copy that
    // lines up with the design's result stage
    logic [SAMPLES-1:0] c_word, d_word;
    logic               c_seam, d_seam, c_rise, c_fall, d_rise, d_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_word <= '0; c_seam <= 1'b0; c_rise <= 1'b0; c_fall <= 1'b0;
            d_word <= '0; d_seam <= 1'b0; d_rise <= 1'b0; d_fall <= 1'b0;
        end else begin
            c_word <= sample_i;
            c_seam <= c_word[SAMPLES-1];
            if (cmd_stb_i && cmd_addr_i == ADDR_W'(SENS_ADDR)) begin
                c_rise <= cmd_data_i[0];
                c_fall <= cmd_data_i[1];
            end
            d_word <= c_word;
            d_seam <= c_seam;
            d_rise <= c_rise;
            d_fall <= c_fall;
        end
    end

    logic [SAMPLES-1:0] prev_bits, exp_hit;
    logic [FINE_W-1:0]  exp_idx;

    always_comb begin
        prev_bits = {d_word[SAMPLES-2:0], d_seam};
        exp_hit   = ({SAMPLES{d_rise}} &  d_word & ~prev_bits)
                  | ({SAMPLES{d_fall}} & ~d_word &  prev_bits);
        exp_idx   = '0;
        for (int i = SAMPLES - 1; i >= 0; i--) begin
            if (exp_hit[i]) exp_idx = FINE_W'(i);
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!evt_stb_o && evt_fine_o == '0));

    a_r9_idle_fine_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_stb_o |-> evt_fine_o == '0);

    a_r7_no_strobe_without_enabled_edge: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb_o |-> (|exp_hit));

    a_r10_strobe_for_each_enabled_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (|exp_hit) |-> evt_stb_o);

    a_r4_fine_bit_holds_new_level: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb_o |-> (d_word[evt_fine_o] != prev_bits[evt_fine_o]));

    a_r8_earliest_edge_reported: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stb_o |-> evt_fine_o == exp_idx);

endmodule

bind ttl_edge_stamper ttl_edge_stamper_chk #(
    .SAMPLES   (SAMPLES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SENS_ADDR (SENS_ADDR),
    .FINE_W    (FINE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stb_i  (cmd_stb_i),
    .cmd_addr_i (cmd_addr_i),
    .cmd_data_i (cmd_data_i),
    .sample_i   (sample_i),
    .evt_stb_o  (evt_stb_o),
    .evt_fine_o (evt_fine_o)
);

// File: tb/test_ttl_edge_stamper.sv
`timescale 1ns/1ps
module test_ttl_edge_stamper;

    localparam int SAMPLES = 8;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 2;
    localparam int FINE_W  = 3;
    localparam int NROWS   = 19;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_stb = 1'b0;
    logic [ADDR_W-1:0]  cmd_addr = '0;
    logic [DATA_W-1:0]  cmd_data = '0;
    logic [SAMPLES-1:0] sample = '0;
    logic               evt_stb;
    logic [FINE_W-1:0]  evt_fine;

    always #4 clk = ~clk;   // 125 MHz

    ttl_edge_stamper i_ttl_edge_stamper (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_stb_i  (cmd_stb),
        .cmd_addr_i (cmd_addr),
        .cmd_data_i (cmd_data),
        .sample_i   (sample),
        .evt_stb_o  (evt_stb),
        .evt_fine_o (evt_fine)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [1:0] sens;   // {fall enable, rise enable}
        logic [7:0] word;
        logic       stb;
        logic [2:0] fine;
        logic [3:0] req;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{2'b00, 8'hFF, 1'b0, 3'd0, 4'd9},   // R9 sensitivity off
        '{2'b11, 8'h00, 1'b1, 3'd0, 4'd6},   // R6 fall on seam after FF
        '{2'b11, 8'hFE, 1'b1, 3'd1, 4'd4},   // R4 rise at 1
        '{2'b11, 8'hFF, 1'b0, 3'd0, 4'd9},   // R9 steady high
        '{2'b11, 8'h7F, 1'b1, 3'd7, 4'd5},   // R5 fall at 7
        '{2'b11, 8'h00, 1'b0, 3'd0, 4'd9},   // R9 steady low
        '{2'b11, 8'hC0, 1'b1, 3'd6, 4'd4},   // R4 rise at 6
        '{2'b11, 8'hFF, 1'b0, 3'd0, 4'd9},   // R9 no change from C0
        '{2'b01, 8'h0F, 1'b0, 3'd0, 4'd7},   // R7 fall ignored, rise only
        '{2'b01, 8'h00, 1'b0, 3'd0, 4'd7},   // R7 nothing new
        '{2'b01, 8'hF0, 1'b1, 3'd4, 4'd7},   // R7 rise at 4
        '{2'b01, 8'h01, 1'b0, 3'd0, 4'd7},   // R7 fall at 1 ignored
        '{2'b10, 8'h55, 1'b1, 3'd1, 4'd8},   // R8 fall-only, rise at 0 skipped
        '{2'b11, 8'h80, 1'b1, 3'd7, 4'd4},   // R4 rise at 7
        '{2'b11, 8'h00, 1'b1, 3'd0, 4'd6},   // R6 fall on seam after 80
        '{2'b11, 8'hAA, 1'b1, 3'd1, 4'd8},   // R8 earliest of several
        '{2'b11, 8'h7F, 1'b1, 3'd7, 4'd5},   // R5 fall at 7 after AA
        '{2'b11, 8'h01, 1'b1, 3'd0, 4'd6},   // R6 rise on seam after 7F
        '{2'b00, 8'hFE, 1'b0, 3'd0, 4'd9}    // R9 off again
    };

    task automatic check(input string tag, input logic stb_e, input logic [2:0] fine_e);
        n_checks++;
        if (evt_stb !== stb_e || evt_fine !== fine_e) begin
            n_errs++;
            $display("FAIL %s: stb/fine actual %0b/%0d expected %0b/%0d",
                     tag, evt_stb, evt_fine, stb_e, fine_e);
        end
    endtask

    // Called at a falling edge; returns at a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        cmd_stb  = 1'b1;
        cmd_addr = a;
        cmd_data = d;
        @(negedge clk);
        cmd_stb  = 1'b0;
    endtask

    // Present a word, registered at the next edge, result after the one after
    task automatic send(input logic [7:0] w);
        sample = w;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] cur_sens;
        cur_sens = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 1'b0, 3'd0);

        // Vector table
        for (int r = 0; r < NROWS; r++) begin
            if (ROWS[r].sens != cur_sens) begin
                wr(2'd2, ROWS[r].sens);   // R2 sensitivity write
                cur_sens = ROWS[r].sens;
            end
            send(ROWS[r].word);
            check($sformatf("R%0d row %0d", ROWS[r].req, r), ROWS[r].stb, ROWS[r].fine);
        end

        // R2: write both enables, then a seam fall
        wr(2'd2, 2'b11);
        send(8'h00);
        check("R2 both enabled", 1'b1, 3'd0);

        // R3: other addresses and an unstrobed cycle leave sensitivity alone
        wr(2'd1, 2'b00);
        wr(2'd3, 2'b00);
        cmd_addr = 2'd2;
        cmd_data = 2'b00;
        @(negedge clk);
        send(8'hFF);
        check("R3 sensitivity kept", 1'b1, 3'd0);

        // R10: latency and single-cycle pulse
        sample = 8'h00;
        @(posedge clk);
        @(negedge clk);
        check("R10 not early", 1'b0, 3'd0);
        @(posedge clk);
        @(negedge clk);
        check("R10 pulse", 1'b1, 3'd0);
        @(posedge clk);
        @(negedge clk);
        check("R10 pulse ends", 1'b0, 3'd0);

        // R1: reset clears sensitivity
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 1'b0, 3'd0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        send(8'hFF);
        check("R1 sensitivity cleared", 1'b0, 3'd0);
        wr(2'd2, 2'b10);
        send(8'h00);
        check("R2 fall only", 1'b1, 3'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule